// File: doc/BRIEF.md
# Power-Down and Calibration Sequencer

This block is the control state machine that decides when a data converter runs its calibration and when it enters or leaves low-power mode. It watches a power-down request level and a manual calibration request. It also handles the start-up event, which is the release of reset. From these it produces four outputs: a calibration-busy flag, a powered-down flag, an enable for the data output drivers, and a flag that marks the output pipeline as holding valid samples.

The analog calibration is modelled by a counter of fixed length. Calibration always runs to completion. A power-down request that arrives during a calibration takes effect only after the calibration ends. Power-down has priority over a manual calibration request that arrives in the same cycle. A manual request made while powered down is dropped and is not kept for later. After power-down is released, the pipeline contents are stale. The valid flag therefore stays low for a set pipeline latency.

All inputs are synchronous to `clk`. The outputs are decoded from registered state.

Top module: `pwrcal_seq`

## Requirements
- R1: While reset is asserted and directly after it, the block is in power-on wait: `pwr_off`=1, `out_en`=0, `cal_busy`=0, `data_ok`=0.
- R2: In power-on wait, the first clock edge that samples `pd_req`=0 starts the power-on calibration. `cal_busy` is 1 from that edge for exactly CAL_CYCLES cycles. The block then becomes active with `pwr_off`=0, `out_en`=1 and `data_ok`=1.
- R3: If `pd_req` is 1 during a calibration, the calibration still lasts CAL_CYCLES cycles and `pwr_off` stays 0 until it ends. At the edge where `cal_busy` falls, the block goes powered down (`pwr_off`=1, `out_en`=0).
- R4: While `pd_req` is 1 in power-on wait, no calibration starts and `pwr_off` stays 1.
- R5: While powered down, rising edges of `cal_req` are ignored and `cal_busy` stays 0. A `cal_req` still held at 1 when power-down is released does not start a calibration afterwards.
- R6: In active state, an edge that samples `pd_req`=1 makes the block powered down after that edge, even when a `cal_req` rising edge arrives in the same cycle: `pwr_off`=1, `out_en`=0, `data_ok`=0, `cal_busy`=0.
- R7: When powered down, the edge that samples `pd_req`=0 makes the block active (`out_en`=1). `data_ok` stays 0 for PIPE_LAT cycles and is 1 from the following cycle on.
- R8: In active state, a 0-to-1 change of `cal_req` starts a calibration lasting CAL_CYCLES cycles. A `cal_req` held at 1 does not retrigger. A new rising edge during a calibration neither extends nor restarts it.
- R9: During a calibration, `out_en`=1 and `data_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; its release is the start-up event |
| pd_req | input | 1 | Power-down request level; 1 requests low-power mode |
| cal_req | input | 1 | Manual calibration request; acts on its rising edge |
| cal_busy | output | 1 | Calibration in progress |
| pwr_off | output | 1 | Low-power mode (also during power-on wait) |
| out_en | output | 1 | Drive enable for the data output buses |
| data_ok | output | 1 | Output pipeline holds valid data |

## Verification
Each output comes straight from the state register, so a change on `pd_req` or `cal_req` shows at the outputs one clock edge after the edge that samples it. The bench therefore drives inputs 1 ns after a rising edge and samples 1 ns after the next one.

Calibration length is found by counting the sampled cycles in which `cal_busy` is high and comparing the count with CAL_CYCLES. The latency mask is checked cycle by cycle: the valid flag must read low for PIPE_LAT samples after the release edge and high on the sample after those.

// File: rtl/pcs_pkg.sv
`timescale 1ns/1ps
package pcs_pkg;

  typedef enum logic [1:0] {
    S_WAIT   = 2'd0,
    S_CAL    = 2'd1,
    S_ACTIVE = 2'd2,
    S_OFF    = 2'd3
  } pcs_state_t;

  // counter width able to hold values 0..n-1 (at least one bit)
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // load value so that a down counter reaching zero spans n cycles
  function automatic int span_load(input int n);
    return (n < 1) ? 0 : n - 1;
  endfunction

endpackage

// File: rtl/pcs_rise.sv
`timescale 1ns/1ps
module pcs_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic din_q;

  always_ff @(posedge clk) begin
    if (!rst_n) din_q <= 1'b0;
    else        din_q <= din;
  end

  assign rise = din & ~din_q;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R8

endmodule

// File: rtl/pcs_cal_timer.sv
`timescale 1ns/1ps
module pcs_cal_timer import pcs_pkg::*; #(
  parameter int CAL_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int CW = cnt_w(CAL_CYCLES);
  localparam logic [CW-1:0] LOADV = CW'(span_load(CAL_CYCLES));

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (start)                  cnt_q <= LOADV;
    else if (run && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done = run && (cnt_q == '0);

  AST_CAL_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done || (CAL_CYCLES < 2)); // R2

endmodule

// File: rtl/pcs_lat_timer.sv
`timescale 1ns/1ps
module pcs_lat_timer import pcs_pkg::*; #(
  parameter int PIPE_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int LW = cnt_w(PIPE_LAT + 1);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= LW'(PIPE_LAT);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  AST_LAT_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R7

endmodule

// File: rtl/pwrcal_seq.sv
`timescale 1ns/1ps
module pwrcal_seq import pcs_pkg::*; #(
  parameter int CAL_CYCLES = 12,
  parameter int PIPE_LAT   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  input  logic cal_req,
  output logic cal_busy,
  output logic pwr_off,
  output logic out_en,
  output logic data_ok
);
  localparam int BW = cnt_w(CAL_CYCLES + 1) + 1;

  pcs_state_t state_q, state_d;
  logic cal_rise;
  logic cal_start;
  logic cal_done;
  logic lat_load;
  logic lat_busy;

  pcs_rise u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cal_req),
    .rise (cal_rise)
  );

  // next state: power-down outranks a manual request; calibration never aborts
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_WAIT:   state_d = pd_req ? S_WAIT : S_CAL;
      S_CAL:    if (cal_done) state_d = pd_req ? S_OFF : S_ACTIVE;
      S_ACTIVE: if (pd_req) state_d = S_OFF;
                else if (cal_rise) state_d = S_CAL;
      S_OFF:    state_d = pd_req ? S_OFF : S_ACTIVE;
      default:  state_d = S_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= S_WAIT;
    else        state_q <= state_d;
  end

  assign cal_start = (state_d == S_CAL) && (state_q != S_CAL);
  assign lat_load  = (state_q == S_OFF) && (state_d == S_ACTIVE);

  pcs_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk  (clk),
    .rst_n(rst_n),
    .start(cal_start),
    .run  (state_q == S_CAL),
    .done (cal_done)
  );

  pcs_lat_timer #(.PIPE_LAT(PIPE_LAT)) u_lat (
    .clk  (clk),
    .rst_n(rst_n),
    .load (lat_load),
    .busy (lat_busy)
  );

  assign cal_busy = (state_q == S_CAL);
  assign pwr_off  = (state_q == S_OFF) || (state_q == S_WAIT);
  assign out_en   = (state_q == S_CAL) || (state_q == S_ACTIVE);
  assign data_ok  = (state_q == S_ACTIVE) && !lat_busy;

  // observer: length of the current cal_busy run
  logic [BW-1:0] busy_len;
  always_ff @(posedge clk) begin
    if (!rst_n)        busy_len <= '0;
    else if (cal_busy) busy_len <= busy_len + 1'b1;
    else               busy_len <= '0;
  end

  AST_CAL_EXACT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> (busy_len == BW'(CAL_CYCLES))); // R2

  AST_CAL_RUNS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && !cal_done) |=> cal_busy); // R3

  AST_OFF_NO_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_OFF) |=> !cal_busy); // R5

  AST_PD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_ACTIVE) && pd_req) |=> (pwr_off && !cal_busy)); // R6

  AST_STALE_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwr_off) && (state_q == S_ACTIVE) && (PIPE_LAT > 0)) |-> !data_ok); // R7

  AST_VALID_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    data_ok |-> (out_en && !cal_busy)); // R9

endmodule

// File: tb/sim_pwrcal_seq.sv
`timescale 1ns/1ps
module sim_pwrcal_seq;
  localparam int CAL = 12;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 1'b1;
  logic cal_req = 1'b0;
  logic cal_busy, pwr_off, out_en, data_ok;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwrcal_seq #(.CAL_CYCLES(CAL), .PIPE_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .cal_req(cal_req),
    .cal_busy(cal_busy), .pwr_off(pwr_off), .out_en(out_en), .data_ok(data_ok)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // counts samples with cal_busy high, starting from one already seen high
  task automatic run_out_cal(input int seen, output int total);
    total = seen;
    while (cal_busy === 1'b1 && total < 1000) begin
      step();
      if (cal_busy === 1'b1) total++;
    end
  endtask

  task automatic t_reset_and_pd_hold();
    rst_n = 1'b0; pd_req = 1'b1; cal_req = 1'b0;
    step(); step();
    chk("R1 pwr_off in reset", pwr_off, 1'b1);
    chk("R1 out_en in reset", out_en, 1'b0);
    chk("R1 cal_busy in reset", cal_busy, 1'b0);
    chk("R1 data_ok in reset", data_ok, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) step();
    chk("R4 no cal while pd held", cal_busy, 1'b0);
    chk("R4 still powered down", pwr_off, 1'b1);
  endtask

  task automatic t_power_on_cal();
    int n;
    pd_req = 1'b0;
    step();
    chk("R2 power-on cal starts", cal_busy, 1'b1);
    chk("R9 out_en during cal", out_en, 1'b1);
    run_out_cal(1, n);
    chk_int("R2 power-on cal length", n, CAL);
    chk("R2 active out_en", out_en, 1'b1);
    chk("R2 active pwr_off", pwr_off, 1'b0);
    chk("R2 active data_ok", data_ok, 1'b1);
  endtask

  task automatic t_manual_cal();
    int n;
    cal_req = 1'b1;
    step();
    chk("R8 manual cal starts", cal_busy, 1'b1);
    chk("R9 data_ok low in cal", data_ok, 1'b0);
    cal_req = 1'b0;
    step();
    cal_req = 1'b1;
    step();
    run_out_cal(3, n);
    chk_int("R8 cal length with re-edge", n, CAL);
    for (int i = 0; i < 3; i++) step();
    chk("R8 held level no retrigger", cal_busy, 1'b0);
    chk("R8 data_ok back", data_ok, 1'b1);
    cal_req = 1'b0;
    step();
  endtask

  task automatic t_pd_during_cal();
    int n;
    cal_req = 1'b1;
    step();
    cal_req = 1'b0;
    pd_req = 1'b1;
    step();
    chk("R3 cal continues under pd", cal_busy, 1'b1);
    chk("R3 not yet powered down", pwr_off, 1'b0);
    run_out_cal(2, n);
    chk_int("R3 cal length under pd", n, CAL);
    chk("R3 powered down after cal", pwr_off, 1'b1);
    chk("R3 outputs disabled", out_en, 1'b0);
  endtask

  task automatic t_cal_while_off();
    cal_req = 1'b1; step();
    cal_req = 1'b0; step();
    cal_req = 1'b1; step(); step(); step();
    chk("R5 cal ignored when off", cal_busy, 1'b0);
    chk("R5 stays off", pwr_off, 1'b1);
    pd_req = 1'b0;
    step();
    chk("R7 wake out_en", out_en, 1'b1);
    chk("R7 wake pwr_off", pwr_off, 1'b0);
    chk("R5 no remembered cal", cal_busy, 1'b0);
    chk("R7 stale right after wake", data_ok, 1'b0);
    for (int i = 1; i < LAT; i++) begin
      step();
      chk("R7 stale during latency", data_ok, 1'b0);
    end
    step();
    chk("R7 valid after latency", data_ok, 1'b1);
    chk("R5 still no cal", cal_busy, 1'b0);
    cal_req = 1'b0;
    step();
  endtask

  task automatic t_priority();
    pd_req = 1'b1; cal_req = 1'b1;
    step();
    chk("R6 pd wins pwr_off", pwr_off, 1'b1);
    chk("R6 pd wins no cal", cal_busy, 1'b0);
    chk("R6 out_en off", out_en, 1'b0);
    chk("R6 data_ok off", data_ok, 1'b0);
    pd_req = 1'b0;
    step();
    chk("R6 no cal after release", cal_busy, 1'b0);
    cal_req = 1'b0;
    for (int i = 0; i < LAT; i++) step();
    chk("R7 valid again", data_ok, 1'b1);
  endtask

  task automatic t_reset_pd_low();
    rst_n = 1'b0; pd_req = 1'b0;
    step();
    chk("R1 reset from active", pwr_off, 1'b1);
    rst_n = 1'b1;
    step();
    chk("R2 immediate power-on cal", cal_busy, 1'b1);
  endtask

  initial begin
    t_reset_and_pd_hold();
    t_power_on_cal();
    t_manual_cal();
    t_pd_during_cal();
    t_cal_while_off();
    t_priority();
    t_reset_pd_low();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule